// File: doc/BRIEF.md
# Zero-Overhead Loop Cache Controller

This block sits beside the fetch stage of a 16-bit DSP sequencer and runs hardware loops without branch instructions. It watches every fetched word. When a loop word with a nonzero body length arrives, it records where the body starts and ends and how many passes to make. While that first loop runs from program memory, it copies each body word into a 15-word on-chip store. At the end of each pass it steers the program counter back to the start until the pass count runs out.

A loop word with a body length of zero replays the body last recorded. The body words then come from the store instead of program memory. After the final replayed pass, the block sends the program counter to the word that follows the replay instruction. For every accepted fetch the block supplies the next program counter and the source it was chosen from. It also supplies the word to execute, the store index with write and hit flags, and the cycle cost of the word.

The fetch side is a valid/ready stream. A word and its PC are taken on a cycle where `fetch_valid` and `fetch_ready` are both high. The block lowers `fetch_ready` for exactly one cycle after it accepts a replay instruction, which models that instruction's second cycle. The fetch source must hold its word, or present the PC it has been given, until the word is taken. All outputs other than `fetch_ready` are combinational and are meaningful only on an accepting cycle.

Top module: `lcc_loop_cache`

## Requirements
- R1: After reset, no loop is recorded (start, end and resume are all 16'hFFFF) and the pass count is zero. An ordinary word at PC p therefore yields `next_pc` = p+1, `pc_sel` = 0 (sequential), no hit and `fetch_ready` high.
- R2: A word is a loop word only when bits 15:11 equal 5'b01110. The pass field K is bits 6:0 and the body length NI is bits 10:7. Any other value of bits 15:11 is an ordinary word.
- R3: A loop word with NI nonzero at PC p records start = p+1 and end = p+NI+1, loads the pass count with K+1, gives `next_pc` = p+1 with `pc_sel` = 0, and costs 1 cycle.
- R4: An ordinary word at PC p with p+1 equal to the recorded end and a pass count above 1 decrements the count and gives `next_pc` = start with `pc_sel` = 1. The body therefore runs K+1 times in total.
- R5: The same word with a pass count of 1 clears the count. If a resume address is held, it gives `next_pc` = resume with `pc_sel` = 2 and invalidates the resume address. Otherwise it gives `next_pc` = p+1 with `pc_sel` = 0.
- R6: A loop word with NI zero at PC p, while a start is recorded, loads the pass count with K+1, holds p+1 as the resume address, gives `next_pc` = start with `pc_sel` = 1, and costs 2 cycles.
- R7: `fetch_ready` is low for exactly the one cycle that follows the acceptance of an R6 replay, and high otherwise.
- R8: During a recording loop (R3), each accepted word whose PC lies in [start, end) raises `cache_wr` with `cache_idx` = PC - start, and is stored at that index.
- R9: During a replay (R6), a word whose PC lies in [start, end) raises `cache_hit`. `exec_word` then comes from the store at index PC - start, and `fetch_word` is ignored.
- R10: A loop word with NI zero while no start is recorded is a no-op: `next_pc` = p+1, `pc_sel` = 0, cost 1 cycle, and `fetch_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetched word and PC are present |
| fetch_ready | output | 1 | Block accepts a word this cycle |
| fetch_pc | input | 16 | PC of the presented word |
| fetch_word | input | 16 | Word read from program memory |
| exec_word | output | 16 | Word to execute (store contents on a hit) |
| next_pc | output | 16 | PC to fetch next |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 loop start, 2 resume |
| cache_idx | output | 4 | Store index for the current word |
| cache_wr | output | 1 | Current word is written to the store |
| cache_hit | output | 1 | Current word is served from the store |
| exec_cycles | output | 2 | Cycle cost of the current word |

## Verification
The bench builds the block with its default parameters: 16-bit words and addresses, a 4-bit body length giving the full 15-entry store, and a 7-bit pass field. Random programs draw body lengths over the whole 0 to 15 range, so the store is filled up to its last index and replays of the longest body occur. Pass counts are kept to 1 to 4 passes so that many loops, nested starts and exits fit in a short run. Directed programs cover a replay issued before any loop exists, near-miss opcodes, and replays after program memory has been overwritten, which exposes any word that was fetched instead of read from the store.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_LOOP   = 2'd1,
    SEL_RESUME = 2'd2
  } pc_sel_e;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_FILL   = 2'd1,
    MODE_REPLAY = 2'd2
  } loop_mode_e;

  typedef struct packed {
    logic is_loop;
    logic is_fill;
    logic is_replay;
  } loop_kind_t;

endpackage

// File: rtl/lcc_decode.sv
module lcc_decode #(
  parameter int DW     = 16,
  parameter int KW     = 7,
  parameter int NIW    = 4,
  parameter int OPW    = 5,
  parameter logic [OPW-1:0] OPCODE = 5'h0E
) (
  input  logic [DW-1:0]       word,
  output lcc_pkg::loop_kind_t kind,
  output logic [KW-1:0]       k_field,
  output logic [NIW-1:0]      ni_field
);
  localparam int NI_LSB = KW;
  localparam int OP_LSB = DW - OPW;

  logic op_match;

  assign op_match = (word[DW-1:OP_LSB] == OPCODE);
  assign k_field  = word[KW-1:0];
  assign ni_field = word[NI_LSB +: NIW];

  assign kind.is_loop   = op_match;
  assign kind.is_fill   = op_match && (ni_field != '0);
  assign kind.is_replay = op_match && (ni_field == '0);

  always_comb begin
    assert (!(kind.is_fill && kind.is_replay)) else $error("p_kind_excl_r2");
  end
endmodule

// File: rtl/lcc_store.sv
module lcc_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 15,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0]    slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign slot_we[i] = wr_en && (wr_idx == IW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (rd_idx == IW'(j)) rd_data = slot_q[j];
    end
  end

  p_one_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_we) <= 1);

  p_slot_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) || (rd_data == $past(wr_data)));
endmodule

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
  import lcc_pkg::*;
#(
  parameter int AW  = 16,
  parameter int KW  = 7,
  parameter int NIW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_valid,
  output logic           fetch_ready,
  input  logic [AW-1:0]  fetch_pc,
  input  loop_kind_t     kind,
  input  logic [KW-1:0]  k_field,
  input  logic [NIW-1:0] ni_field,
  output logic [AW-1:0]  next_pc,
  output pc_sel_e        pc_sel,
  output logic [1:0]     cycles,
  output logic [NIW-1:0] cache_idx,
  output logic           cache_wr,
  output logic           cache_hit
);
  localparam int CW = KW + 1;
  localparam logic [AW-1:0] INVALID = '1;

  logic [AW-1:0] start_q, end_q, resume_q;
  logic [AW-1:0] start_d, end_d, resume_d;
  logic [CW-1:0] count_q, count_d;
  loop_mode_e    mode_q, mode_d;
  logic          stall_q;
  logic          accept, in_body, replay_taken;
  logic [AW-1:0] pc_inc, offset;

  assign fetch_ready = !stall_q;
  assign accept      = fetch_valid && !stall_q;
  assign pc_inc      = fetch_pc + AW'(1);
  assign offset      = fetch_pc - start_q;

  assign in_body   = (start_q != INVALID) && (fetch_pc >= start_q) && (fetch_pc < end_q);
  assign cache_idx = in_body ? offset[NIW-1:0] : '0;
  assign cache_hit = in_body && (mode_q == MODE_REPLAY);
  assign cache_wr  = accept && in_body && (mode_q == MODE_FILL);

  assign replay_taken = kind.is_replay && (start_q != INVALID);

  always_comb begin
    start_d  = start_q;
    end_d    = end_q;
    resume_d = resume_q;
    count_d  = count_q;
    mode_d   = mode_q;
    next_pc  = pc_inc;
    pc_sel   = SEL_SEQ;
    cycles   = 2'd1;
    if (kind.is_fill) begin
      start_d = pc_inc;
      end_d   = pc_inc + AW'(ni_field);
      count_d = CW'(k_field) + CW'(1);
      mode_d  = MODE_FILL;
    end else if (replay_taken) begin
      count_d  = CW'(k_field) + CW'(1);
      resume_d = pc_inc;
      next_pc  = start_q;
      pc_sel   = SEL_LOOP;
      cycles   = 2'd2;
      mode_d   = MODE_REPLAY;
    end else if (!kind.is_loop && (count_q != '0) && (pc_inc == end_q)) begin
      if (count_q > CW'(1)) begin
        count_d = count_q - CW'(1);
        next_pc = start_q;
        pc_sel  = SEL_LOOP;
      end else begin
        count_d = '0;
        mode_d  = MODE_IDLE;
        if (resume_q != INVALID) begin
          next_pc  = resume_q;
          pc_sel   = SEL_RESUME;
          resume_d = INVALID;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= INVALID;
      end_q    <= INVALID;
      resume_q <= INVALID;
      count_q  <= '0;
      mode_q   <= MODE_IDLE;
      stall_q  <= 1'b0;
    end else begin
      stall_q <= accept && replay_taken;
      if (accept) begin
        start_q  <= start_d;
        end_q    <= end_d;
        resume_q <= resume_d;
        count_q  <= count_d;
        mode_q   <= mode_d;
      end
    end
  end

  p_stall_after_replay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind.is_replay && start_q != INVALID) |=> !fetch_ready);

  p_stall_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ready |=> fetch_ready);

  p_resume_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pc_sel == SEL_RESUME) |=> (resume_q == INVALID));

  p_count_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind.is_loop && (kind.is_fill || start_q != INVALID))
      |=> (count_q == CW'($past(k_field)) + CW'(1)));

  p_count_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !kind.is_loop) |=> (count_q <= $past(count_q)));

  p_hit_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cache_hit && cache_wr));
endmodule

// File: rtl/lcc_loop_cache.sv
module lcc_loop_cache #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int KW  = 7,
  parameter int NIW = 4,
  parameter int OPW = 5,
  parameter logic [OPW-1:0] OPCODE = 5'h0E
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_valid,
  output logic           fetch_ready,
  input  logic [AW-1:0]  fetch_pc,
  input  logic [DW-1:0]  fetch_word,
  output logic [DW-1:0]  exec_word,
  output logic [AW-1:0]  next_pc,
  output logic [1:0]     pc_sel,
  output logic [NIW-1:0] cache_idx,
  output logic           cache_wr,
  output logic           cache_hit,
  output logic [1:0]     exec_cycles
);
  localparam int DEPTH = (1 << NIW) - 1;

  lcc_pkg::loop_kind_t kind;
  lcc_pkg::pc_sel_e    sel;
  logic [KW-1:0]       k_field;
  logic [NIW-1:0]      ni_field;
  logic [DW-1:0]       store_word;

  assign exec_word = cache_hit ? store_word : fetch_word;
  assign pc_sel    = sel;

  lcc_decode #(.DW(DW), .KW(KW), .NIW(NIW), .OPW(OPW), .OPCODE(OPCODE)) u_decode (
    .word     (exec_word),
    .kind     (kind),
    .k_field  (k_field),
    .ni_field (ni_field)
  );

  lcc_store #(.DW(DW), .DEPTH(DEPTH), .IW(NIW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cache_wr),
    .wr_idx  (cache_idx),
    .wr_data (fetch_word),
    .rd_idx  (cache_idx),
    .rd_data (store_word)
  );

  lcc_ctrl #(.AW(AW), .KW(KW), .NIW(NIW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .fetch_pc    (fetch_pc),
    .kind        (kind),
    .k_field     (k_field),
    .ni_field    (ni_field),
    .next_pc     (next_pc),
    .pc_sel      (sel),
    .cycles      (exec_cycles),
    .cache_idx   (cache_idx),
    .cache_wr    (cache_wr),
    .cache_hit   (cache_hit)
  );
endmodule

// File: tb/sim_lcc_loop_cache.sv
`timescale 1ns/1ps
module sim_lcc_loop_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic [15:0] fetch_word = '0;
  logic        fetch_ready, cache_wr, cache_hit;
  logic [15:0] exec_word, next_pc;
  logic [1:0]  pc_sel, exec_cycles;
  logic [3:0]  cache_idx;

  always #2 clk = ~clk;

  lcc_loop_cache u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_pc(fetch_pc), .fetch_word(fetch_word), .exec_word(exec_word),
    .next_pc(next_pc), .pc_sel(pc_sel), .cache_idx(cache_idx), .cache_wr(cache_wr),
    .cache_hit(cache_hit), .exec_cycles(exec_cycles)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] prog [256];
  logic [15:0] m_start, m_end, m_res;
  logic [15:0] m_cache [15];
  int          m_cnt, m_mode;
  bit          m_stall;
  logic [15:0] pc_cur;
  int          passes;
  logic [15:0] watch_pc;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] plain_word();
    logic [15:0] w = 16'($urandom);
    if (w[15:11] == 5'h0E) w[15] = ~w[15];
    return w;
  endfunction

  function automatic logic [15:0] loop_word(input int ni, input int k);
    return {5'h0E, 4'(ni), 7'(k)};
  endfunction

  task automatic model_reset();
    m_start = 16'hFFFF; m_end = 16'hFFFF; m_res = 16'hFFFF;
    m_cnt = 0; m_mode = 0; m_stall = 0;
  endtask

  // one cycle: drive at negedge, check combinational outputs, advance the model
  task automatic run_cycle(input bit v);
    bit in_body, hit, fill, is_loop;
    logic [15:0] w, eff, inc, e_next;
    logic [3:0] idx;
    int ni, k, e_sel, e_cyc;
    string tag;
    @(negedge clk);
    w = prog[pc_cur[7:0]];
    fetch_valid = v; fetch_pc = pc_cur; fetch_word = w;
    #1;
    chk(fetch_ready == !m_stall, "R7 ready", 32'(fetch_ready), 32'(!m_stall));
    if (v && !m_stall) begin
      inc = pc_cur + 16'd1;
      in_body = (m_start != 16'hFFFF) && (pc_cur >= m_start) && (pc_cur < m_end);
      idx = 4'(pc_cur - m_start);
      hit = in_body && (m_mode == 2);
      fill = in_body && (m_mode == 1);
      eff = hit ? m_cache[idx] : w;
      is_loop = (eff[15:11] == 5'h0E);
      ni = int'(eff[10:7]); k = int'(eff[6:0]);
      e_next = inc; e_sel = 0; e_cyc = 1; tag = "R2 plain";
      if (is_loop && ni != 0) begin
        tag = "R3 fill";
        m_start = inc; m_end = 16'(pc_cur + 16'(ni) + 16'd1); m_cnt = k + 1; m_mode = 1;
      end else if (is_loop && m_start != 16'hFFFF) begin
        tag = "R6 replay";
        m_cnt = k + 1; m_res = inc; e_next = m_start; e_sel = 1; e_cyc = 2; m_mode = 2;
      end else if (is_loop) begin
        tag = "R10 noop";
      end else if (m_cnt != 0 && inc == m_end) begin
        if (m_cnt > 1) begin
          tag = "R4 loopback"; m_cnt--; e_next = m_start; e_sel = 1;
        end else begin
          tag = "R5 exit"; m_cnt = 0; m_mode = 0;
          if (m_res != 16'hFFFF) begin e_next = m_res; e_sel = 2; m_res = 16'hFFFF; end
        end
      end
      chk(next_pc == e_next, {tag, " next_pc"}, 32'(next_pc), 32'(e_next));
      chk(pc_sel == 2'(e_sel), {tag, " pc_sel"}, 32'(pc_sel), 32'(e_sel));
      chk(exec_cycles == 2'(e_cyc), {tag, " cycles"}, 32'(exec_cycles), 32'(e_cyc));
      chk(cache_wr == fill, "R8 cache_wr", 32'(cache_wr), 32'(fill));
      chk(cache_hit == hit, "R9 cache_hit", 32'(cache_hit), 32'(hit));
      chk(exec_word == eff, "R9 exec_word", 32'(exec_word), 32'(eff));
      if (in_body) chk(cache_idx == idx, "R8 cache_idx", 32'(cache_idx), 32'(idx));
      if (fill) m_cache[idx] = w;
      if (pc_cur == watch_pc) passes++;
      m_stall = (e_cyc == 2);
      pc_cur = e_next;
    end else begin
      m_stall = 0;
    end
  endtask

  task automatic run_until(input logic [15:0] target, input int limit);
    for (int i = 0; i < limit && pc_cur != target; i++) run_cycle(1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    watch_pc = 16'hFFFF;
    passes = 0;
    for (int i = 0; i < 256; i++) prog[i] = plain_word();
    prog[3]  = loop_word(0, 5);       // replay before any loop: R10
    prog[4]  = 16'h7A00;              // bits 15:11 = 5'h0F: ordinary, R2
    prog[10] = loop_word(3, 2);       // body 11..13, three passes
    prog[14] = loop_word(0, 1);       // replay twice, then resume at 15
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    pc_cur = 16'd0;

    // R1: reset state seen at the ports
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 16'd0; fetch_word = prog[0];
    #1;
    chk(fetch_ready == 1'b1, "R1 ready", 32'(fetch_ready), 32'd1);
    chk(next_pc == 16'd1, "R1 next_pc", 32'(next_pc), 32'd1);
    chk(pc_sel == 2'd0, "R1 pc_sel", 32'(pc_sel), 32'd0);
    chk(cache_hit == 1'b0, "R1 hit", 32'(cache_hit), 32'd0);
    fetch_valid = 1'b0;

    // directed recording loop: K=2 gives three passes (R4)
    watch_pc = 16'd11;
    run_until(16'd14, 200);
    chk(passes == 3, "R4 pass count", 32'(passes), 32'd3);
    chk(pc_cur == 16'd14, "R5 fall through", 32'(pc_cur), 32'd14);

    // overwrite program memory; the replay must use stored words (R9)
    for (int i = 11; i <= 13; i++) prog[i] = plain_word();
    passes = 0;
    run_until(16'd15, 200);
    chk(passes == 2, "R6 replay passes", 32'(passes), 32'd2);
    chk(pc_cur == 16'd15, "R5 resume", 32'(pc_cur), 32'd15);
    watch_pc = 16'hFFFF;

    // back-pressure idle cycles mixed into a short run
    for (int i = 0; i < 20; i++) run_cycle(1'($urandom % 2));

    // constrained random programs
    for (int round = 0; round < 6; round++) begin
      for (int i = 0; i < 256; i++) begin
        int r = int'($urandom % 10);
        if (r < 8) prog[i] = plain_word();
        else prog[i] = loop_word((r == 9) ? 0 : int'($urandom % 16), int'($urandom % 4));
      end
      pc_cur = 16'($urandom % 32);
      for (int c = 0; c < 1500; c++) begin
        if (pc_cur >= 16'd240) pc_cur = 16'($urandom % 32);
        run_cycle(($urandom % 5) != 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule